// File: doc/BRIEF.md
# Local Bus Ownership Arbiter

This block decides which of several masters owns a shared local bus. Five request lines come in. They stand for an external bus master asking the chip to release the bus, a DMA engine running a burst, the CPU, the same DMA engine making single transfers, and a PCI bridge. The arbiter returns a one-hot grant vector. Grant bit 0 means the bus has been handed to the external master, so the same condition also drives the bus-released flag. A further output says whether the chip should keep driving its write-enable and read/frame strobes while the bus is released.

The current owner keeps the bus until a transfer boundary. A boundary occurs when the owner drops its request or pulses end-of-transfer. At a boundary the arbiter runs a fixed-priority selection again. If the owner still wins, it keeps the grant with no gap. Otherwise the grant is removed, the bus sits idle for one cycle, and then the new winner is granted.

A 32-bit configuration word is reached through a simple write-strobe/read-strobe port. Three of its bits are used:
- bit 0 lets external requests through;
- bit 1 keeps a running DMA burst from being interrupted by an external request;
- bit 2 keeps the strobes driven while the bus is released.

A slave-boot strap input admits external requests even when bit 0 is clear.

Top module: `lbus_arbiter`

## Requirements
- R1: With bit 1 of the configuration clear, a selection grants the highest-ranked eligible requester. The ranking from highest to lowest is: external master (grant bit 0), DMA burst (bit 1), CPU (bit 2), DMA single (bit 3), PCI bridge (bit 4). This applies at a transfer boundary even while a DMA burst is still requesting.
- R2: With bit 1 of the configuration set, the bus is not handed to the external master while the DMA burst owns it and keeps its request asserted. End-of-transfer pulses during the burst do not change this. Once the burst request drops, the external master is granted after the idle cycle.
- R3: An external request (request bit 0) is never granted while configuration bit 0 is 0 and the slave-boot strap is low.
- R4: After reset, the grant vector is all zero, the configuration reads back as 0, and the strobe output-enable is 1.
- R5: With the slave-boot strap high, an external request is granted even though configuration bit 0 is 0.
- R6: While grant bit 0 is set, the strobe output-enable equals configuration bit 2: 0 tri-states the strobes and 1 drives them. While grant bit 0 is clear, the output-enable is 1.
- R7: A read returns configuration bits 2..0 in data bits 2..0, and data bits 31..3 read as 0 whatever was written to them. The read data is 0 when the read strobe is low.
- R8: A granted owner keeps its grant in every cycle in which it still requests and end-of-transfer is low, even if a higher-ranked request arrives.
- R9: At most one grant bit is set. When ownership passes from one requester to another, the grant vector is zero for exactly one cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| slave_boot_i | input | 1 | Slave-boot strap; admits external requests regardless of configuration bit 0 |
| req_i | input | 5 | Requests: 0 external, 1 DMA burst, 2 CPU, 3 DMA single, 4 PCI |
| eot_i | input | 1 | End-of-transfer pulse from the current owner |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_re_i | input | 1 | Configuration read strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data |
| gnt_o | output | 5 | One-hot grant, same bit order as req_i |
| bus_released_o | output | 1 | Bus handed to the external master |
| strobe_oe_o | output | 1 | Output-enable for the write-enable and read/frame strobes |

## Verification
The assertions assume the following about the inputs:
- end-of-transfer is only meaningful while a grant is held;
- each requester holds its request steady until it is granted or chooses to withdraw;
- the slave-boot strap does not toggle around a grant decision.

The stimulus respects these assumptions. It changes inputs only on the falling clock edge and holds requests across the idle gap. It pulses end-of-transfer for one cycle at a time and only while some owner holds the bus. It sets the strap between scenarios, never in the middle of one.

// File: rtl/lbus_arb_pkg.sv
package lbus_arb_pkg;
    localparam int NUM_SRC     = 5;
    localparam int SRC_EXT     = 0;
    localparam int SRC_DBURST  = 1;
    localparam int SRC_CPU     = 2;
    localparam int SRC_DSINGLE = 3;
    localparam int SRC_PCI     = 4;

    localparam int CFG_FIELDS  = 3;

    typedef struct packed {
        logic drive;   // bit 2
        logic hold;    // bit 1
        logic ext_en;  // bit 0
    } cfg_t;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_OWNED = 1'b1
    } arb_st_e;

    typedef struct packed {
        arb_st_e              st;
        logic [NUM_SRC-1:0]   gnt;
    } arb_state_t;
endpackage

// File: rtl/lbus_cfg_reg.sv
module lbus_cfg_reg
    import lbus_arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output cfg_t              cfg_o
);
    localparam int PAD_W = DATA_W - CFG_FIELDS;

    cfg_t cfg_d, cfg_q;
    logic unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:CFG_FIELDS];

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            cfg_d = cfg_t'(wdata_i[CFG_FIELDS-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rdata_o = re_i ? {{PAD_W{1'b0}}, cfg_q} : '0;
    assign cfg_o   = cfg_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:CFG_FIELDS] == '0) else $error("reserved bits nonzero"); // R7

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> cfg_q == $past(wdata_i[CFG_FIELDS-1:0])) else $error("write lost"); // R7
endmodule

// File: rtl/lbus_prio_pick.sv
module lbus_prio_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] win_o
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_rank
        assign win_o[i]    = req_i[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | req_i[i];
    end

    always_comb begin
        AST_PICK_ONEHOT: assert ($onehot0(win_o)) else $error("multi win"); // R9
        AST_PICK_SUBSET: assert ((win_o & ~req_i) == '0) else $error("win w/o req"); // R1
    end
endmodule

// File: rtl/lbus_strobe_ctl.sv
module lbus_strobe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic released_i,
    input  logic drive_i,
    output logic oe_o
);
    assign oe_o = ~released_i | drive_i;

    AST_HIZ_WHEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (released_i && !drive_i) |-> !oe_o) else $error("strobe driven"); // R6
    AST_DRIVEN_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        !released_i |-> oe_o) else $error("strobe floated"); // R6
endmodule

// File: rtl/lbus_arbiter.sv
module lbus_arbiter
    import lbus_arb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_boot_i,
    input  logic [4:0]        req_i,
    input  logic              eot_i,
    input  logic              cfg_we_i,
    input  logic              cfg_re_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic [4:0]        gnt_o,
    output logic              bus_released_o,
    output logic              strobe_oe_o
);
    cfg_t               cfg;
    arb_state_t         s_d, s_q;
    logic [NUM_SRC-1:0] elig;
    logic [NUM_SRC-1:0] win;
    logic               owner_live;
    logic               hold_now;
    logic               boundary;

    lbus_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .re_i    (cfg_re_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .cfg_o   (cfg)
    );

    always_comb begin
        owner_live = |(s_q.gnt & req_i);
        hold_now   = cfg.hold & s_q.gnt[SRC_DBURST] & req_i[SRC_DBURST];
        elig       = req_i;
        elig[SRC_EXT] = req_i[SRC_EXT] & (cfg.ext_en | slave_boot_i) & ~hold_now;
        boundary   = ~owner_live | eot_i;
    end

    lbus_prio_pick #(.N(NUM_SRC)) u_pick (
        .req_i (elig),
        .win_o (win)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ARB_IDLE: begin
                if (|win) begin
                    s_d.st  = ARB_OWNED;
                    s_d.gnt = win;
                end
            end
            ARB_OWNED: begin
                if (boundary && (win != s_q.gnt)) begin
                    s_d.st  = ARB_IDLE;
                    s_d.gnt = '0;
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gnt_o          = s_q.gnt;
    assign bus_released_o = s_q.gnt[SRC_EXT];

    lbus_strobe_ctl u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .released_i (bus_released_o),
        .drive_i    (cfg.drive),
        .oe_o       (strobe_oe_o)
    );

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o)) else $error("grant not onehot"); // R9
    AST_GAP_ON_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |=> (gnt_o == $past(gnt_o)) || (gnt_o == '0)) else $error("no gap"); // R9
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(gnt_o & req_i)) && !eot_i) |=> gnt_o == $past(gnt_o)) else $error("preempted"); // R8
    AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_o[SRC_EXT]) |-> $past(req_i[SRC_EXT] && (cfg.ext_en || slave_boot_i)))
        else $error("ext granted while gated"); // R3
    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o[SRC_DBURST] && cfg.hold && req_i[SRC_DBURST]) |=> !gnt_o[SRC_EXT])
        else $error("burst interrupted"); // R2
endmodule

// File: tb/lbus_arbiter_test.sv
module lbus_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slave_boot = 1'b0;
    logic [4:0]  req = '0;
    logic        eot = 1'b0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  gnt;
    logic        released;
    logic        soe;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lbus_arbiter uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .slave_boot_i   (slave_boot),
        .req_i          (req),
        .eot_i          (eot),
        .cfg_we_i       (we),
        .cfg_re_i       (re),
        .cfg_wdata_i    (wdata),
        .cfg_rdata_o    (rdata),
        .gnt_o          (gnt),
        .bus_released_o (released),
        .strobe_oe_o    (soe)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(logic [31:0] v);
        we = 1'b1; wdata = v;
        tick();
        we = 1'b0; wdata = '0;
    endtask

    task automatic quiesce();
        req = '0; eot = 1'b0;
        tick(); tick();
    endtask

    task automatic t_reset();
        chk("R4 grant after reset", 32'(gnt), 0);
        chk("R4 strobe oe after reset", 32'(soe), 1);
        re = 1'b1; #1;
        chk("R4 config after reset", rdata, 0);
        re = 1'b0; #1;
        chk("R7 read data idle", rdata, 0);
    endtask

    task automatic t_reserved();
        cfg_write(32'hFFFF_FFFF);
        re = 1'b1; #1;
        chk("R7 reserved read zero", rdata, 32'h7);
        re = 1'b0;
        cfg_write(32'hFFFF_FFF8);
        re = 1'b1; #1;
        chk("R7 reserved write no effect", rdata, 32'h0);
        re = 1'b0;
    endtask

    task automatic t_ext_gated();
        cfg_write(32'h0);
        req = 5'b00001;
        tick(); tick(); tick();
        chk("R3 ext refused", 32'(gnt), 0);
        req = 5'b00101;
        tick();
        chk("R3 cpu granted not ext", 32'(gnt), 32'b00100);
        quiesce();
    endtask

    task automatic t_slave();
        cfg_write(32'h0);
        slave_boot = 1'b1;
        req = 5'b00001;
        tick();
        chk("R5 slave override grant", 32'(gnt), 1);
        chk("R5 released flag", 32'(released), 1);
        quiesce();
        slave_boot = 1'b0;
    endtask

    task automatic t_order();
        cfg_write(32'h1);
        req = 5'b11111;
        tick();
        chk("R1 ext first", 32'(gnt), 32'b00001);
        req[0] = 1'b0; tick();
        chk("R9 gap after ext", 32'(gnt), 0);
        tick();
        chk("R1 burst second", 32'(gnt), 32'b00010);
        req[1] = 1'b0; tick();
        chk("R9 gap after burst", 32'(gnt), 0);
        tick();
        chk("R1 cpu third", 32'(gnt), 32'b00100);
        req[2] = 1'b0; tick(); tick();
        chk("R1 dma single fourth", 32'(gnt), 32'b01000);
        req[3] = 1'b0; tick(); tick();
        chk("R1 pci last", 32'(gnt), 32'b10000);
        quiesce();
    endtask

    task automatic t_no_preempt();
        cfg_write(32'h1);
        req = 5'b00100;
        tick();
        chk("R8 cpu owns", 32'(gnt), 32'b00100);
        req = 5'b00111;
        tick(); tick();
        chk("R8 cpu kept despite higher", 32'(gnt), 32'b00100);
        eot = 1'b1; tick(); eot = 1'b0;
        chk("R9 gap at handover", 32'(gnt), 0);
        tick();
        chk("R8 ext after boundary", 32'(gnt), 32'b00001);
        quiesce();
    endtask

    task automatic t_burst_free();
        cfg_write(32'h1);
        req = 5'b00010;
        tick();
        chk("R1 burst owns", 32'(gnt), 32'b00010);
        req = 5'b00011;
        tick();
        chk("R8 burst not preempted", 32'(gnt), 32'b00010);
        eot = 1'b1; tick(); eot = 1'b0;
        chk("R1 burst yields at boundary", 32'(gnt), 0);
        tick();
        chk("R1 ext wins mid-burst when hold clear", 32'(gnt), 32'b00001);
        quiesce();
    endtask

    task automatic t_burst_hold();
        cfg_write(32'h3);
        req = 5'b00010;
        tick();
        req = 5'b00011;
        for (int k = 0; k < 3; k++) begin
            eot = 1'b1; tick(); eot = 1'b0; tick();
        end
        chk("R2 burst held through eot", 32'(gnt), 32'b00010);
        req = 5'b00001;
        tick();
        chk("R2 gap after burst end", 32'(gnt), 0);
        tick();
        chk("R2 ext after burst end", 32'(gnt), 32'b00001);
        quiesce();
    endtask

    task automatic t_strobe();
        cfg_write(32'h1);
        req = 5'b00001;
        tick();
        chk("R6 hiz when released drive=0", 32'(soe), 0);
        cfg_write(32'h5);
        chk("R6 driven when released drive=1", 32'(soe), 1);
        cfg_write(32'h1);
        req = 5'b00000; tick();
        chk("R6 driven when not released", 32'(soe), 1);
        quiesce();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_ext_gated();
        t_slave();
        t_order();
        t_no_preempt();
        t_burst_free();
        t_burst_hold();
        t_strobe();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule